// File: doc/BRIEF.md
# Oversampled Serial Receiver with Break and Line-Activity Status

This block receives asynchronous serial characters from a single line. An external rate generator supplies a sample tick at sixteen times the bit rate. The block assembles characters of 8 or 9 data bits, least significant bit first, each followed by one stop bit. Each bit is resolved by a majority vote of three samples taken near the middle of the bit. The block keeps four status flags:

- line activity
- break
- framing error
- receive-data-full

A host reaches the block through single-cycle strobes: a status read, a data read and a data write. Each strobe takes effect on the clock edge where it is high. There is no back-pressure on either side. A newly completed character overwrites the receive data register whether or not the previous one was read. A write simply replaces the byte held for transmission.

A break is a character in which every data bit and the stop bit are 0. The break flag behaves like a latched event. The host clears it with a two-step sequence: a status read that sees the flag set, then a data read. After a break is accepted, the line must show a 1 on an idle sample before another break can be reported. The activity flag follows the start-bit search. It rises on the first low sample, and it falls either when the start bit fails its vote or when a full character time of 1s has passed.

Top module: `serial_rx_status`

## Requirements
- R1: When an accepted break completes, the break flag (stat_o bit 1), the framing-error flag (bit 2) and the full flag (bit 3) are all 1 on the next cycle, and the receive data register reads 0.
- R2: In 9-bit mode, the ninth-bit output bit8_o is 0 after a break. It holds the ninth received bit after a normal character, and it is always 0 in 8-bit mode.
- R3: A completed character loads its low byte into rdata_o and sets the full flag. The framing-error flag is set exactly when the stop-bit vote is 0.
- R4: The break and framing-error flags clear only on a data read that follows a status read made while that flag was set. A data read with no such status read leaves them set.
- R5: After a break has set the break flag, no further break is reported until an idle-state sample of the line has been 1.
- R6: The activity flag (stat_o bit 0) sets on a sample tick at which the receiver is idle and the line is 0.
- R7: The activity flag clears when the vote over the three start-bit samples at tick positions 8, 9 and 10 is 1 (a false start).
- R8: The activity flag clears after the line has been 1 on 160 consecutive idle ticks in 8-bit mode, or on 176 in 9-bit mode.
- R9: Reset clears all four flags but leaves the receive data register unchanged. A data write loads wdata_i into txdata_o.
- R10: A data read clears the full flag unless a character completes in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | Oversample tick, 16 per bit |
| rx_i | input | 1 | Serial line, already synchronous to clk |
| nine_bit_i | input | 1 | 1 selects 9 data bits |
| rd_stat_i | input | 1 | Status read strobe |
| rd_data_i | input | 1 | Data read strobe |
| wr_data_i | input | 1 | Data write strobe |
| wdata_i | input | 8 | Byte to transmit |
| stat_o | output | 4 | {full, framing, break, activity} |
| rdata_o | output | 8 | Received byte |
| bit8_o | output | 1 | Ninth received bit |
| txdata_o | output | 8 | Byte held for transmission |

## Verification
The bench targets the break handshake in three situations:

- A data read with no prior status read. A design that clears on any data read would drop the flag there.
- A line held low for several character times. A design that re-arms at the end of each character would report a second break.
- A two-tick noise pulse. A receiver without the mid-bit vote would start assembling a character from it and would never lower the activity flag.

It also checks that the activity flag falls after exactly one idle character time, that the ninth bit is cleared by a break in 9-bit mode, and that a mid-run reset leaves the receive data register intact.

// File: rtl/srx_pkg.sv
package srx_pkg;
  localparam int SRX_DW = 8;
  localparam int SRX_BW = SRX_DW + 1;

  typedef enum logic [1:0] {FR_IDLE, FR_START, FR_DATA, FR_STOP} fr_state_e;

  typedef struct packed {
    logic              valid;
    logic              brk;
    logic              ferr;
    logic [SRX_BW-1:0] data;
  } rx_evt_t;

  localparam int STAT_ACT  = 0;
  localparam int STAT_BRK  = 1;
  localparam int STAT_FE   = 2;
  localparam int STAT_FULL = 3;
endpackage

// File: rtl/srx_voter.sv
module srx_voter #(
  parameter int OVS = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick_i,
  input  logic run_i,
  input  logic rx_i,
  output logic vote_o,
  output logic vote_bit_o,
  output logic slot_end_o
);
  localparam int CW  = $clog2(OVS + 1);
  localparam int MID = OVS / 2;

  logic [CW-1:0] cnt;
  logic [CW-1:0] idx;
  logic          s_a, s_b;

  assign idx = cnt + 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
      s_a <= 1'b0;
      s_b <= 1'b0;
    end else if (tick_i) begin
      if (!run_i) begin
        cnt <= CW'(1);
      end else begin
        cnt <= (idx == CW'(OVS)) ? '0 : idx;
        if (idx == CW'(MID))     s_a <= rx_i;
        if (idx == CW'(MID + 1)) s_b <= rx_i;
      end
    end
  end

  assign vote_o     = tick_i && run_i && (idx == CW'(MID + 2));
  assign vote_bit_o = (s_a & s_b) | (s_a & rx_i) | (s_b & rx_i);
  assign slot_end_o = tick_i && run_i && (idx == CW'(OVS));
endmodule

// File: rtl/srx_framer.sv
module srx_framer
  import srx_pkg::*;
#(
  parameter int OVS = 16
) (
  input  logic    clk,
  input  logic    rst_n,
  input  logic    tick_i,
  input  logic    rx_i,
  input  logic    nine_i,
  input  logic    vote_i,
  input  logic    vote_bit_i,
  input  logic    slot_end_i,
  output logic    run_o,
  output logic    act_set_o,
  output logic    act_clr_o,
  output rx_evt_t evt_o
);
  localparam int BW   = SRX_BW;
  localparam int IW   = $clog2(BW + 1);
  localparam int LIMW = $clog2(OVS * (BW + 2) + 1);

  fr_state_e       st;
  logic [BW-1:0]   sh;
  logic [IW-1:0]   bidx;
  logic [LIMW-1:0] idle;
  logic            armed;
  logic [LIMW-1:0] lim;
  logic [IW-1:0]   last;
  logic [BW-1:0]   word;
  logic            brk_now;

  assign lim     = nine_i ? LIMW'(OVS * (BW + 2)) : LIMW'(OVS * (BW + 1));
  assign last    = nine_i ? IW'(BW - 1) : IW'(BW - 2);
  assign word    = nine_i ? sh : {1'b0, sh[BW-1:1]};
  assign brk_now = !vote_bit_i && (word == '0);
  assign run_o   = (st != FR_IDLE);

  always_comb begin
    act_set_o = tick_i && (st == FR_IDLE) && !rx_i;
    act_clr_o = (vote_i && (st == FR_START) && vote_bit_i) ||
                (tick_i && (st == FR_IDLE) && rx_i && (idle == lim - 1'b1));
    evt_o.valid = vote_i && (st == FR_STOP) && !(brk_now && !armed);
    evt_o.brk   = brk_now;
    evt_o.ferr  = !vote_bit_i;
    evt_o.data  = word;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st    <= FR_IDLE;
      sh    <= '0;
      bidx  <= '0;
      idle  <= '0;
      armed <= 1'b0;
    end else begin
      unique case (st)
        FR_IDLE: if (tick_i) begin
          if (!rx_i) begin
            st   <= FR_START;
            idle <= '0;
          end else begin
            armed <= 1'b1;
            if (idle < lim) idle <= idle + 1'b1;
          end
        end
        FR_START: begin
          if (vote_i && vote_bit_i) begin
            st <= FR_IDLE;
          end else if (slot_end_i) begin
            st   <= FR_DATA;
            bidx <= '0;
          end
        end
        FR_DATA: begin
          if (vote_i) sh <= {vote_bit_i, sh[BW-1:1]};
          if (slot_end_i) begin
            if (bidx == last) st <= FR_STOP;
            else              bidx <= bidx + 1'b1;
          end
        end
        FR_STOP: if (vote_i) begin
          st <= FR_IDLE;
          if (brk_now && armed) armed <= 1'b0;
        end
        default: st <= FR_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/srx_status.sv
module srx_status
  import srx_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              act_set_i,
  input  logic              act_clr_i,
  input  rx_evt_t           evt_i,
  input  logic              rd_stat_i,
  input  logic              rd_data_i,
  input  logic              wr_data_i,
  input  logic [SRX_DW-1:0] wdata_i,
  output logic [3:0]        stat_o,
  output logic [SRX_DW-1:0] rdata_o,
  output logic              bit8_o,
  output logic [SRX_DW-1:0] txdata_o
);
  logic act, brk, fe, full;
  logic seen_brk, seen_fe;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act      <= 1'b0;
      brk      <= 1'b0;
      fe       <= 1'b0;
      full     <= 1'b0;
      seen_brk <= 1'b0;
      seen_fe  <= 1'b0;
    end else begin
      if (act_set_i)      act <= 1'b1;
      else if (act_clr_i) act <= 1'b0;
      if (rd_stat_i) begin
        seen_brk <= brk;
        seen_fe  <= fe;
      end else if (rd_data_i) begin
        seen_brk <= 1'b0;
        seen_fe  <= 1'b0;
      end
      brk  <= (brk & !(rd_data_i & seen_brk)) | (evt_i.valid & evt_i.brk);
      fe   <= (fe & !(rd_data_i & seen_fe)) | (evt_i.valid & evt_i.ferr);
      full <= (full & !rd_data_i) | evt_i.valid;
    end
  end

  always_ff @(posedge clk) begin
    if (evt_i.valid) begin
      rdata_o <= evt_i.data[SRX_DW-1:0];
      bit8_o  <= evt_i.data[SRX_DW];
    end
    if (wr_data_i) txdata_o <= wdata_i;
  end

  always_comb begin
    stat_o            = '0;
    stat_o[STAT_ACT]  = act;
    stat_o[STAT_BRK]  = brk;
    stat_o[STAT_FE]   = fe;
    stat_o[STAT_FULL] = full;
  end
endmodule

// File: rtl/serial_rx_status.sv
module serial_rx_status
  import srx_pkg::*;
#(
  parameter int OVS = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_i,
  input  logic              rx_i,
  input  logic              nine_bit_i,
  input  logic              rd_stat_i,
  input  logic              rd_data_i,
  input  logic              wr_data_i,
  input  logic [SRX_DW-1:0] wdata_i,
  output logic [3:0]        stat_o,
  output logic [SRX_DW-1:0] rdata_o,
  output logic              bit8_o,
  output logic [SRX_DW-1:0] txdata_o
);
  logic    run, vote, vote_bit, slot_end, act_set, act_clr;
  rx_evt_t evt;

  srx_voter #(.OVS(OVS)) u_voter (
    .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .run_i(run), .rx_i(rx_i),
    .vote_o(vote), .vote_bit_o(vote_bit), .slot_end_o(slot_end)
  );

  srx_framer #(.OVS(OVS)) u_framer (
    .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .rx_i(rx_i), .nine_i(nine_bit_i),
    .vote_i(vote), .vote_bit_i(vote_bit), .slot_end_i(slot_end),
    .run_o(run), .act_set_o(act_set), .act_clr_o(act_clr), .evt_o(evt)
  );

  srx_status u_status (
    .clk(clk), .rst_n(rst_n), .act_set_i(act_set), .act_clr_i(act_clr), .evt_i(evt),
    .rd_stat_i(rd_stat_i), .rd_data_i(rd_data_i), .wr_data_i(wr_data_i),
    .wdata_i(wdata_i), .stat_o(stat_o), .rdata_o(rdata_o), .bit8_o(bit8_o),
    .txdata_o(txdata_o)
  );
endmodule

// File: rtl/srx_checker.sv
module srx_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       tick_i,
  input logic       rx_i,
  input logic       rd_data_i,
  input logic [3:0] stat_o
);
  logic brk_d, hi_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      brk_d <= 1'b0;
      hi_q  <= 1'b0;
    end else begin
      brk_d <= stat_o[1];
      if (stat_o[1] && !brk_d) hi_q <= tick_i && rx_i;
      else if (tick_i && rx_i) hi_q <= 1'b1;
    end
  end

  AST_BRK_WITH_FE_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(stat_o[1]) |-> (stat_o[2] && stat_o[3])); // R1
  AST_BRK_CLR_BY_DREAD: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(stat_o[1]) |-> $past(rd_data_i)); // R4
  AST_BRK_NEEDS_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(stat_o[1]) |-> hi_q); // R5
  AST_ACT_SET_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(stat_o[0]) |-> ($past(tick_i) && !$past(rx_i))); // R6
  AST_ACT_CLR_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(stat_o[0]) |-> $past(tick_i)); // R7
endmodule

bind serial_rx_status srx_checker u_chk (
  .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .rx_i(rx_i),
  .rd_data_i(rd_data_i), .stat_o(stat_o)
);

// File: tb/serial_rx_status_test.sv
`timescale 1ns/1ps
module serial_rx_status_test;
  logic clk = 0, rst_n = 0, tick_i = 0, rx_i = 1, nine_bit_i = 0;
  logic rd_stat_i = 0, rd_data_i = 0, wr_data_i = 0;
  logic [7:0] wdata_i = 0;
  logic [3:0] stat_o;
  logic [7:0] rdata_o, txdata_o;
  logic bit8_o;
  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #2 clk = ~clk;

  serial_rx_status uut (
    .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .rx_i(rx_i), .nine_bit_i(nine_bit_i),
    .rd_stat_i(rd_stat_i), .rd_data_i(rd_data_i), .wr_data_i(wr_data_i),
    .wdata_i(wdata_i), .stat_o(stat_o), .rdata_o(rdata_o), .bit8_o(bit8_o),
    .txdata_o(txdata_o)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // behavioural reference model
  int m_busy, m_t, m_a, m_b, m_idle, m_armed, m_act, m_brk, m_fe, m_full;
  int m_sb, m_sf, m_rxd, m_b8, m_have, m_tx, m_txv;
  int q[$];
  int sbo, sfo, bo, fo, nb, pos, slot, maj, val, isz;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_busy = 0; m_armed = 0; m_idle = 0; m_act = 0; m_brk = 0;
      m_fe = 0; m_full = 0; m_sb = 0; m_sf = 0;
    end else begin
      sbo = m_sb; sfo = m_sf; bo = m_brk; fo = m_fe;
      if (rd_stat_i) begin m_sb = bo; m_sf = fo; end
      else if (rd_data_i) begin m_sb = 0; m_sf = 0; end
      if (rd_data_i) begin
        if (sbo != 0) m_brk = 0;
        if (sfo != 0) m_fe = 0;
        m_full = 0;
      end
      if (wr_data_i) begin m_tx = wdata_i; m_txv = 1; end
      if (tick_i) begin
        nb = nine_bit_i ? 9 : 8;
        if (m_busy == 0) begin
          if (!rx_i) begin
            m_busy = 1; m_t = 1; m_act = 1; m_idle = 0; q.delete();
          end else begin
            m_armed = 1;
            if (m_idle < 16 * (nb + 2)) begin
              m_idle++;
              if (m_idle == 16 * (nb + 2)) m_act = 0;
            end
          end
        end else begin
          m_t++;
          pos = (m_t - 1) % 16 + 1;
          slot = (m_t - 1) / 16;
          if (pos == 8) m_a = rx_i;
          if (pos == 9) m_b = rx_i;
          if (pos == 10) begin
            maj = (m_a + m_b + int'(rx_i)) >= 2;
            if (slot == 0) begin
              if (maj != 0) begin m_busy = 0; m_act = 0; end
            end else if (slot <= nb) begin
              q.push_back(maj);
            end else begin
              m_busy = 0;
              val = 0;
              foreach (q[i]) val |= q[i] << i;
              isz = (maj == 0) && (val == 0);
              if (!(isz != 0 && m_armed == 0)) begin
                m_full = 1;
                if (maj == 0) m_fe = 1;
                if (isz != 0) begin m_brk = 1; m_armed = 0; end
                m_rxd = val & 255;
                m_b8 = (nb == 9) ? ((val >> 8) & 1) : 0;
                m_have = 1;
              end
            end
          end
        end
      end
    end
  end

  always @(negedge clk) if (!done) begin
    check(stat_o[0] === (m_act != 0), "R6 activity vs model", stat_o[0], m_act);
    check(stat_o[1] === (m_brk != 0), "R1 break vs model", stat_o[1], m_brk);
    check(stat_o[2] === (m_fe != 0), "R3 framing vs model", stat_o[2], m_fe);
    check(stat_o[3] === (m_full != 0), "R10 full vs model", stat_o[3], m_full);
    if (m_have != 0) begin
      check(rdata_o === 8'(m_rxd), "R3 rdata vs model", rdata_o, m_rxd);
      check(bit8_o === (m_b8 != 0), "R2 bit8 vs model", bit8_o, m_b8);
    end
    if (m_txv != 0) check(txdata_o === 8'(m_tx), "R9 txdata vs model", txdata_o, m_tx);
  end

  initial forever begin
    @(negedge clk); #1; tick_i = ~tick_i;
  end

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
    #1;
  endtask

  task automatic send(input int v, input int n, input int stop);
    rx_i = 0; cyc(32);
    for (int i = 0; i < n; i++) begin rx_i = (v >> i) & 1; cyc(32); end
    rx_i = stop[0]; cyc(32);
    rx_i = 1;
  endtask

  task automatic rd_stat();
    rd_stat_i = 1; cyc(1); rd_stat_i = 0;
  endtask

  task automatic rd_data();
    rd_data_i = 1; cyc(1); rd_data_i = 0;
  endtask

  initial begin
    cyc(3);
    check(stat_o == 4'h0, "R9 reset flags", stat_o, 0);
    rst_n = 1; cyc(200);
    send(8'hA5, 8, 1); cyc(4);
    check(stat_o[3] == 1, "R3 full after char", stat_o[3], 1);
    check(stat_o[2] == 0, "R3 no framing", stat_o[2], 0);
    check(rdata_o == 8'hA5, "R3 data", rdata_o, 8'hA5);
    check(stat_o[0] == 1, "R6 act held", stat_o[0], 1);
    rd_data(); cyc(1);
    check(stat_o[3] == 0, "R10 full cleared", stat_o[3], 0);
    cyc(400);
    check(stat_o[0] == 0, "R8 idle clears act", stat_o[0], 0);
    rx_i = 0; cyc(4); rx_i = 1; cyc(2);
    check(stat_o[0] == 1, "R6 act on glitch", stat_o[0], 1);
    cyc(40);
    check(stat_o[0] == 0, "R7 false start", stat_o[0], 0);
    check(stat_o[3] == 0, "R7 no char from glitch", stat_o[3], 0);
    cyc(400);
    rx_i = 0; cyc(330);
    check(stat_o[1] == 1, "R1 break", stat_o[1], 1);
    check(stat_o[2] == 1, "R1 framing", stat_o[2], 1);
    check(stat_o[3] == 1, "R1 full", stat_o[3], 1);
    check(rdata_o == 0, "R1 data zero", rdata_o, 0);
    rd_data(); cyc(2);
    check(stat_o[1] == 1, "R4 data read alone keeps break", stat_o[1], 1);
    check(stat_o[2] == 1, "R4 data read alone keeps framing", stat_o[2], 1);
    rd_stat(); rd_data(); cyc(1);
    check(stat_o[1] == 0, "R4 handshake clears break", stat_o[1], 0);
    check(stat_o[2] == 0, "R4 handshake clears framing", stat_o[2], 0);
    cyc(400);
    check(stat_o[1] == 0, "R5 no break without high", stat_o[1], 0);
    rx_i = 1; cyc(600);
    rd_stat(); rd_data(); cyc(2);
    rx_i = 0; cyc(330);
    check(stat_o[1] == 1, "R5 rearmed break", stat_o[1], 1);
    rx_i = 1; cyc(600);
    rd_stat(); rd_data(); cyc(2);
    send(8'h3C, 8, 1); cyc(4);
    rst_n = 0; cyc(3);
    check(stat_o == 4'h0, "R9 reset clears flags", stat_o, 0);
    check(rdata_o == 8'h3C, "R9 reset keeps data", rdata_o, 8'h3C);
    rst_n = 1; cyc(100);
    nine_bit_i = 1; cyc(50);
    send(9'h15A, 9, 1); cyc(4);
    check(rdata_o == 8'h5A, "R3 nine-bit low byte", rdata_o, 8'h5A);
    check(bit8_o == 1, "R2 ninth bit", bit8_o, 1);
    rd_data(); cyc(600);
    rx_i = 0; cyc(360);
    check(stat_o[1] == 1, "R1 nine-bit break", stat_o[1], 1);
    check(bit8_o == 0, "R2 break clears ninth bit", bit8_o, 0);
    rx_i = 1; cyc(700);
    rd_stat(); rd_data(); nine_bit_i = 0; cyc(50);
    send(8'h81, 8, 0); cyc(4);
    check(stat_o[2] == 1, "R3 framing on bad stop", stat_o[2], 1);
    check(stat_o[1] == 0, "R3 not a break", stat_o[1], 0);
    rd_stat(); rd_data();
    wdata_i = 8'h77; wr_data_i = 1; cyc(1); wr_data_i = 0; cyc(1);
    check(txdata_o == 8'h77, "R9 tx write", txdata_o, 8'h77);
    cyc(50);
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #600000;
    if (!done) begin
      done = 1;
      check(0, "watchdog", 0, 1);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule